// File: doc/BRIEF.md
# Tape Controller Order and Interrupt Acknowledge Unit

This block sits between an I/O channel and a group of magnetic tape drives. It takes the orders the channel issues to a drive (start, test I/O, test device, halt, acknowledge interrupt), each carrying a unit address. For each order it returns one status word, and it keeps the interrupt state of the controller. There are two interrupt sources. The first is a single channel interrupt, tagged with the drive that raised it. The second is a per-drive set of rewind-complete flags, which the rewind-done pulses load.

An acknowledge serves the channel interrupt first. When none is pending, it serves the lowest-numbered drive whose rewind has finished. The block drives an interrupt-pending level and a device-interrupt level back to the channel. It also emits a one-cycle start pulse when a drive is launched and a one-cycle unusual-end pulse when a busy drive is halted. Each pulse comes with the drive number.

Orders use a valid/ready handshake. Every accepted order completes in one clock, and its response is registered.

Top module: `tape_irq_ctl`

## Requirements
- R1: While reset is asserted, `ord_ready`, `resp_valid`, both pulses and both interrupt lines are low. `ord_ready` rises within a few cycles of reset release.
- R2: An order whose unit address is at or above `N_UNITS`, or names a unit whose `unit_en` bit is 0, returns `resp_nodev`=1 with a zero word. It launches nothing, halts nothing and clears nothing.
- R3: Start (op code 0) returns the test I/O status. It launches the unit (`start_pulse` with `start_unit`) only when no unit is busy and the addressed unit is neither busy nor rewinding.
- R4: The status bits of a unit are: bit0 device busy (busy or rewinding), bit1 controller busy (any unit busy), bit2 rewinding, bit3 rewind interrupt pending, bit4 channel interrupt owned by this unit, and bits 7:5 zero. Test I/O (op 1) returns bits 1:0 only. Test device (op 2) returns all eight bits.
- R5: Halt (op 3) returns the test I/O status. If the unit is busy, halt clears its busy state and pulses `uend_pulse` with `uend_unit`.
- R6: Halt clears the channel interrupt only when the addressed unit owns it. Halt always clears that unit's rewind interrupt and its rewinding state.
- R7: Acknowledge (op 4) with a channel interrupt pending clears it and reports the owner with interrupt flag 0. Rewind flags are left as they are, so `dev_int` stays high while any remain.
- R8: Acknowledge with no channel interrupt pending clears the lowest set rewind flag and reports that unit with flag 1. With nothing pending it returns a zero word.
- R9: The acknowledge word holds the unit status ANDed with `ACK_MASK` (default 8'h07) in bits 7:0, the unit number in bits 10:8 and the interrupt flag in bit 15. All other bits are zero.
- R10: `dev_int` is high exactly when any rewind flag is set. `int_pending` is high when `dev_int` is high or a channel interrupt is pending. A `rew_done` pulse raises `dev_int` on the next cycle.
- R11: When a clear and a set of the same state land in the same cycle, the set wins. This covers `rew_done` against halt or acknowledge of that unit's flag, `chi_req` against a channel interrupt clear, and `rew_start` against a halt.
- R12: Op codes 5 to 7 return a zero word and change nothing.
- R13: `resp_valid` and the response fields appear in the cycle after the accepting edge. `start_pulse` and `uend_pulse` last exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ord_valid | input | 1 | Order present |
| ord_ready | output | 1 | Block can accept an order |
| ord_op | input | 3 | Order code (0 start, 1 test I/O, 2 test device, 3 halt, 4 acknowledge) |
| ord_unit | input | ADDR_W | Addressed unit |
| unit_en | input | N_UNITS | Per-unit enable |
| rew_start | input | N_UNITS | Rewind begins on a unit (pulse) |
| rew_done | input | N_UNITS | Rewind finished on a unit (pulse) |
| op_done | input | N_UNITS | Unit operation finished (pulse) |
| chi_req | input | 1 | Channel interrupt raised (pulse) |
| chi_unit | input | UNIT_W | Unit owning the new channel interrupt |
| resp_valid | output | 1 | Response present |
| resp_nodev | output | 1 | Addressed unit absent or disabled |
| resp_word | output | 16 | Status or acknowledge word |
| start_pulse | output | 1 | Unit launched |
| start_unit | output | UNIT_W | Launched unit |
| uend_pulse | output | 1 | Unusual end to channel |
| uend_unit | output | UNIT_W | Halted unit |
| int_pending | output | 1 | Any interrupt pending |
| dev_int | output | 1 | Rewind interrupt pending |

## Verification
All order results are due one cycle after the accepting clock edge. This covers the response word, the no-device flag and both pulses. Interrupt lines reflect state updated on that same edge, so they also settle one cycle after any order or input pulse. The bench drives inputs on the falling edge, advances its model once per cycle, and compares every output on the next falling edge. Each expectation is therefore compared exactly one register stage after its cause.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic [2:0] {
    ORD_START = 3'd0,
    ORD_TIO   = 3'd1,
    ORD_TDV   = 3'd2,
    ORD_HALT  = 3'd3,
    ORD_ACK   = 3'd4
  } ord_e;

  localparam int RESP_W    = 16;
  localparam int UNIT_LSB  = 8;
  localparam int FLAG_BIT  = 15;
  localparam logic [7:0] TIO_MASK = 8'h03;
endpackage

// File: rtl/tc_rst_sync.sv
module tc_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic q1, q2;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      q1 <= 1'b0;
      q2 <= 1'b0;
    end else begin
      q1 <= 1'b1;
      q2 <= q1;
    end
  end

  assign rst_n_out = q2;
endmodule

// File: rtl/tc_lowest_pick.sv
module tc_lowest_pick #(
  parameter int N      = 8,
  parameter int IDX_W  = 3
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tc_unit_state.sv
module tc_unit_state #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_en,
  input  logic             halt_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [N-1:0]     op_done,
  input  logic [N-1:0]     rew_start,
  input  logic [N-1:0]     rew_done,
  output logic [N-1:0]     busy,
  output logic [N-1:0]     rewinding
);
  logic [N-1:0] busy_q, busy_d, rew_q, rew_d;
  logic         upd_en;

  always_comb begin
    busy_d = busy_q & ~op_done;
    if (start_en) busy_d[idx] = 1'b1;
    if (halt_en)  busy_d[idx] = 1'b0;
    rew_d = rew_q;
    if (halt_en)  rew_d[idx] = 1'b0;
    rew_d = (rew_d & ~rew_done) | rew_start;
  end

  assign upd_en = start_en | halt_en | (|op_done) | (|rew_start) | (|rew_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      rew_q  <= '0;
    end else if (upd_en) begin
      busy_q <= busy_d;
      rew_q  <= rew_d;
    end
  end

  assign busy      = busy_q;
  assign rewinding = rew_q;
endmodule

// File: rtl/tc_rewind_mask.sv
module tc_rewind_mask #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     set,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [N-1:0]     mask
);
  logic [N-1:0] mask_q, mask_d;

  always_comb begin
    mask_d = mask_q;
    if (clr_en) mask_d[clr_idx] = 1'b0;
    mask_d = mask_d | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 mask_q <= '0;
    else if (clr_en || (|set))  mask_q <= mask_d;
  end

  assign mask = mask_q;
endmodule

// File: rtl/tape_irq_ctl.sv
module tape_irq_ctl
  import tc_pkg::*;
#(
  parameter int         N_UNITS  = 8,
  parameter int         ADDR_W   = 4,
  parameter int         UNIT_W   = $clog2(N_UNITS),
  parameter logic [7:0] ACK_MASK = 8'h07
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ord_valid,
  output logic               ord_ready,
  input  logic [2:0]         ord_op,
  input  logic [ADDR_W-1:0]  ord_unit,
  input  logic [N_UNITS-1:0] unit_en,
  input  logic [N_UNITS-1:0] rew_start,
  input  logic [N_UNITS-1:0] rew_done,
  input  logic [N_UNITS-1:0] op_done,
  input  logic               chi_req,
  input  logic [UNIT_W-1:0]  chi_unit,
  output logic               resp_valid,
  output logic               resp_nodev,
  output logic [15:0]        resp_word,
  output logic               start_pulse,
  output logic [UNIT_W-1:0]  start_unit,
  output logic               uend_pulse,
  output logic [UNIT_W-1:0]  uend_unit,
  output logic               int_pending,
  output logic               dev_int
);
  logic rst_n_s;
  logic ready_q;

  logic [N_UNITS-1:0] busy, rewinding, rwi_mask;
  logic               chi_q, chi_d;
  logic [UNIT_W-1:0]  owner_q, owner_d;
  logic               pick_found;
  logic [UNIT_W-1:0]  pick_idx;
  logic [7:0]         stat [N_UNITS];

  logic              acc, in_range, addr_ok;
  logic [UNIT_W-1:0] uidx;
  ord_e              op;

  logic              start_d, halt_d, uend_d, ack_chi, ack_rwi, nodev_d;
  logic [15:0]       word_d;
  logic              rwi_clr_en;
  logic [UNIT_W-1:0] rwi_clr_idx;

  logic              rv_q, nd_q, sp_q, up_q;
  logic [15:0]       word_q;
  logic [UNIT_W-1:0] su_q, uu_q;

  tc_rst_sync u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s));

  tc_unit_state #(.N(N_UNITS), .IDX_W(UNIT_W)) u_units (
    .clk(clk), .rst_n(rst_n_s), .start_en(start_d), .halt_en(halt_d),
    .idx(uidx), .op_done(op_done), .rew_start(rew_start), .rew_done(rew_done),
    .busy(busy), .rewinding(rewinding));

  tc_rewind_mask #(.N(N_UNITS), .IDX_W(UNIT_W)) u_rwi (
    .clk(clk), .rst_n(rst_n_s), .set(rew_done), .clr_en(rwi_clr_en),
    .clr_idx(rwi_clr_idx), .mask(rwi_mask));

  tc_lowest_pick #(.N(N_UNITS), .IDX_W(UNIT_W)) u_pick (
    .req(rwi_mask), .found(pick_found), .idx(pick_idx));

  for (genvar g = 0; g < N_UNITS; g++) begin : g_stat
    assign stat[g] = {3'b000,
                      chi_q && (owner_q == UNIT_W'(g)),
                      rwi_mask[g],
                      rewinding[g],
                      |busy,
                      busy[g] | rewinding[g]};
  end

  assign acc      = ord_valid & ready_q;
  assign in_range = ord_unit < ADDR_W'(N_UNITS);
  assign uidx     = ord_unit[UNIT_W-1:0];
  assign addr_ok  = in_range && unit_en[uidx];
  assign op       = ord_e'(ord_op);

  always_comb begin
    start_d = 1'b0;
    halt_d  = 1'b0;
    uend_d  = 1'b0;
    ack_chi = 1'b0;
    ack_rwi = 1'b0;
    nodev_d = 1'b0;
    word_d  = '0;
    if (acc) begin
      if (!addr_ok) begin
        nodev_d = 1'b1;
      end else begin
        case (op)
          ORD_START: begin
            word_d[7:0] = stat[uidx] & TIO_MASK;
            start_d     = !(|busy) && !stat[uidx][0];
          end
          ORD_TIO: word_d[7:0] = stat[uidx] & TIO_MASK;
          ORD_TDV: word_d[7:0] = stat[uidx];
          ORD_HALT: begin
            word_d[7:0] = stat[uidx] & TIO_MASK;
            halt_d      = 1'b1;
            uend_d      = busy[uidx];
          end
          ORD_ACK: begin
            if (chi_q) begin
              ack_chi = 1'b1;
              word_d[7:0] = stat[owner_q] & ACK_MASK;
              word_d[UNIT_LSB +: UNIT_W] = owner_q;
            end else if (pick_found) begin
              ack_rwi = 1'b1;
              word_d[7:0] = stat[pick_idx] & ACK_MASK;
              word_d[UNIT_LSB +: UNIT_W] = pick_idx;
              word_d[FLAG_BIT] = 1'b1;
            end
          end
          default: word_d = '0;
        endcase
      end
    end
  end

  assign rwi_clr_en  = halt_d | ack_rwi;
  assign rwi_clr_idx = halt_d ? uidx : pick_idx;

  always_comb begin
    chi_d   = chi_q;
    owner_d = owner_q;
    if (ack_chi || (halt_d && chi_q && owner_q == uidx)) chi_d = 1'b0;
    if (chi_req) begin
      chi_d   = 1'b1;
      owner_d = chi_unit;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ready_q <= 1'b0;
      chi_q   <= 1'b0;
      owner_q <= '0;
      rv_q    <= 1'b0;
      nd_q    <= 1'b0;
      word_q  <= '0;
      sp_q    <= 1'b0;
      su_q    <= '0;
      up_q    <= 1'b0;
      uu_q    <= '0;
    end else begin
      ready_q <= 1'b1;
      chi_q   <= chi_d;
      owner_q <= owner_d;
      rv_q    <= acc;
      nd_q    <= nodev_d;
      word_q  <= word_d;
      sp_q    <= start_d;
      su_q    <= start_d ? uidx : '0;
      up_q    <= uend_d;
      uu_q    <= uend_d ? uidx : '0;
    end
  end

  assign ord_ready   = ready_q;
  assign resp_valid  = rv_q;
  assign resp_nodev  = nd_q;
  assign resp_word   = word_q;
  assign start_pulse = sp_q;
  assign start_unit  = su_q;
  assign uend_pulse  = up_q;
  assign uend_unit   = uu_q;
  assign dev_int     = |rwi_mask;
  assign int_pending = chi_q | (|rwi_mask);
endmodule

// File: rtl/tc_checker.sv
module tc_checker #(
  parameter int N_UNITS = 8,
  parameter int ADDR_W  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ord_valid,
  input logic               ord_ready,
  input logic [2:0]         ord_op,
  input logic [ADDR_W-1:0]  ord_unit,
  input logic [N_UNITS-1:0] rew_done,
  input logic               resp_valid,
  input logic               resp_nodev,
  input logic               start_pulse,
  input logic               uend_pulse,
  input logic               int_pending,
  input logic               dev_int
);
  logic acc;
  assign acc = ord_valid && ord_ready;

  assert_nodev_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (ord_unit >= ADDR_W'(N_UNITS))) |=> (resp_nodev && !start_pulse && !uend_pulse));

  assert_start_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> $past(acc && ord_op == 3'd0));

  assert_uend_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    uend_pulse |-> $past(acc && ord_op == 3'd3));

  assert_rwi_raise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|rew_done) |=> dev_int);

  assert_devint_sub_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dev_int |-> int_pending);

  assert_irq_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_pending) |-> $past(acc && (ord_op == 3'd3 || ord_op == 3'd4)));

  assert_pulse_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_pulse, uend_pulse}));

  assert_resp_due_R13: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> resp_valid);

  assert_resp_src_R13: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(acc));
endmodule

bind tape_irq_ctl tc_checker #(.N_UNITS(N_UNITS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ord_valid(ord_valid), .ord_ready(ord_ready),
  .ord_op(ord_op), .ord_unit(ord_unit), .rew_done(rew_done),
  .resp_valid(resp_valid), .resp_nodev(resp_nodev), .start_pulse(start_pulse),
  .uend_pulse(uend_pulse), .int_pending(int_pending), .dev_int(dev_int));

// File: tb/tb_tape_irq_ctl.sv
module tb_tape_irq_ctl;
  localparam int N  = 8;
  localparam int AW = 4;
  localparam int UW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ord_valid;
  logic          ord_ready;
  logic [2:0]    ord_op;
  logic [AW-1:0] ord_unit;
  logic [N-1:0]  unit_en, rew_start, rew_done, op_done;
  logic          chi_req;
  logic [UW-1:0] chi_unit;
  logic          resp_valid, resp_nodev, start_pulse, uend_pulse, int_pending, dev_int;
  logic [15:0]   resp_word;
  logic [UW-1:0] start_unit, uend_unit;

  tape_irq_ctl dut (
    .clk(clk), .rst_n(rst_n), .ord_valid(ord_valid), .ord_ready(ord_ready),
    .ord_op(ord_op), .ord_unit(ord_unit), .unit_en(unit_en), .rew_start(rew_start),
    .rew_done(rew_done), .op_done(op_done), .chi_req(chi_req), .chi_unit(chi_unit),
    .resp_valid(resp_valid), .resp_nodev(resp_nodev), .resp_word(resp_word),
    .start_pulse(start_pulse), .start_unit(start_unit), .uend_pulse(uend_pulse),
    .uend_unit(uend_unit), .int_pending(int_pending), .dev_int(dev_int));

  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  // reference model state
  bit [N-1:0] m_busy, m_rew, m_rwi;
  bit         m_chi;
  bit [UW-1:0] m_owner;
  // expected outputs
  bit         e_valid, e_nodev, e_sp, e_up, e_ip, e_di;
  bit [15:0]  e_word;
  bit [UW-1:0] e_su, e_uu;
  string      tag;

  task automatic chk(input string rq, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s [%s] act=%0h exp=%0h", rq, what, tag, act, exp);
    end
  endtask

  function automatic bit [7:0] tdv(input int u);
    bit [7:0] s;
    s = '0;
    s[0] = m_busy[u] | m_rew[u];
    s[1] = |m_busy;
    s[2] = m_rew[u];
    s[3] = m_rwi[u];
    s[4] = m_chi && (m_owner == UW'(u));
    return s;
  endfunction

  function automatic bit [15:0] ackw(input int u, input bit flag);
    bit [15:0] w;
    w = '0;
    w[7:0]  = tdv(u) & 8'h07;
    w[10:8] = UW'(u);
    w[15]   = flag;
    return w;
  endfunction

  // advance the model by one clock from the inputs now applied
  task automatic model_step();
    bit [N-1:0] nb, nr, nw;
    bit nc;
    bit [UW-1:0] no;
    int u;
    nb = m_busy & ~op_done; nr = m_rew; nw = m_rwi; nc = m_chi; no = m_owner;
    e_valid = 0; e_nodev = 0; e_word = '0; e_sp = 0; e_up = 0; e_su = '0; e_uu = '0;
    u = int'(ord_unit);
    if (ord_valid) begin
      e_valid = 1;
      if (u >= N || !unit_en[u]) e_nodev = 1;
      else begin
        case (ord_op)
          3'd0: begin
            e_word = {8'h0, tdv(u) & 8'h03};
            if (m_busy == 0 && !m_busy[u] && !m_rew[u]) begin
              nb[u] = 1; e_sp = 1; e_su = UW'(u);
            end
          end
          3'd1: e_word = {8'h0, tdv(u) & 8'h03};
          3'd2: e_word = {8'h0, tdv(u)};
          3'd3: begin
            e_word = {8'h0, tdv(u) & 8'h03};
            if (m_busy[u]) begin e_up = 1; e_uu = UW'(u); end
            nb[u] = 0;
            if (m_chi && m_owner == UW'(u)) nc = 0;
            nw[u] = 0; nr[u] = 0;
          end
          3'd4: begin
            if (m_chi) begin
              nc = 0; e_word = ackw(int'(m_owner), 1'b0);
            end else begin
              for (int k = 0; k < N; k++) begin
                if (m_rwi[k]) begin
                  e_word = ackw(k, 1'b1); nw[k] = 0; break;
                end
              end
            end
          end
          default: e_word = '0;
        endcase
      end
    end
    nr = (nr & ~rew_done) | rew_start;
    nw = nw | rew_done;
    if (chi_req) begin nc = 1; no = chi_unit; end
    m_busy = nb; m_rew = nr; m_rwi = nw; m_chi = nc; m_owner = no;
    e_di = |nw;
    e_ip = nc | (|nw);
  endtask

  task automatic compare();
    chk("R13", "resp_valid", resp_valid, e_valid);
    chk("R2",  "resp_nodev", resp_nodev, e_nodev);
    chk("R9",  "resp_word",  resp_word,  e_word);
    chk("R3",  "start_pulse", {start_unit, start_pulse}, {e_su, e_sp});
    chk("R5",  "uend_pulse",  {uend_unit, uend_pulse},   {e_uu, e_up});
    chk("R10", "irq_lines",   {int_pending, dev_int},    {e_ip, e_di});
  endtask

  task automatic cyc(input bit v, input int op, input int unit,
                     input bit [N-1:0] rs, input bit [N-1:0] rd, input bit [N-1:0] od,
                     input bit cr, input int cu);
    ord_valid = v; ord_op = 3'(op); ord_unit = AW'(unit);
    rew_start = rs; rew_done = rd; op_done = od; chi_req = cr; chi_unit = UW'(cu);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic order(input int op, input int unit);
    cyc(1'b1, op, unit, '0, '0, '0, 1'b0, 0);
  endtask

  task automatic idle();
    cyc(1'b0, 0, 0, '0, '0, '0, 1'b0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    int seed;
    int w;
    seed = int'($urandom(32'd20240611));
    rst_n = 0; ord_valid = 0; ord_op = '0; ord_unit = '0; unit_en = '1;
    rew_start = '0; rew_done = '0; op_done = '0; chi_req = 0; chi_unit = '0;
    repeat (3) @(negedge clk);
    tag = "reset";
    chk("R1", "reset outputs",
        {ord_ready, resp_valid, start_pulse, uend_pulse, int_pending, dev_int}, 6'b0);
    rst_n = 1;
    w = 0;
    while (!ord_ready && w < 8) begin @(negedge clk); w++; end
    chk("R1", "ready after reset", ord_ready, 1'b1);

    // rewind flags, lowest first
    tag = "rewind order";
    cyc(0, 0, 0, 8'h24, '0, '0, 0, 0);
    order(2, 2);                                   // R4 rewinding bit
    cyc(0, 0, 0, '0, 8'h20, '0, 0, 0);             // R10 dev_int rises
    cyc(0, 0, 0, '0, 8'h04, '0, 0, 0);
    order(4, 0);                                   // R8 unit 2 first
    order(4, 0);                                   // R8 unit 5
    order(4, 0);                                   // R8 nothing pending
    // channel interrupt served before rewind flag
    tag = "chi first";
    cyc(0, 0, 0, '0, 8'h02, '0, 1, 3);
    order(2, 3);                                   // R4 owned bit
    order(4, 0);                                   // R7 owner 3, flag 0
    chk("R7", "dev_int kept", dev_int, 1'b1);
    order(4, 0);                                   // R8 unit 1
    // halt only clears an owned channel interrupt
    tag = "halt owner";
    cyc(0, 0, 0, '0, '0, '0, 1, 3);
    order(3, 4);                                   // R6 kept
    chk("R6", "chi kept", int_pending, 1'b1);
    order(3, 3);                                   // R6 cleared
    chk("R6", "chi cleared", int_pending, 1'b0);
    // start and halt
    tag = "start halt";
    order(0, 1);                                   // R3 launch
    order(0, 2);                                   // R3 refused, ctrl busy
    order(1, 2);                                   // R4 test io
    order(3, 1);                                   // R5 uend
    cyc(0, 0, 0, 8'h40, '0, '0, 0, 0);
    order(0, 6);                                   // R3 refused, rewinding
    order(3, 6);                                   // R6 rewind cancelled
    order(2, 6);
    // same-cycle set wins
    tag = "set wins";
    cyc(1, 3, 6, '0, 8'h40, '0, 0, 0);             // R11 rwi kept
    chk("R11", "rwi survives halt", dev_int, 1'b1);
    cyc(1, 4, 0, '0, 8'h40, '0, 0, 0);             // R11 ack vs set
    chk("R11", "rwi survives ack", dev_int, 1'b1);
    order(4, 0);
    cyc(0, 0, 0, '0, '0, '0, 1, 5);
    cyc(1, 4, 0, '0, '0, '0, 1, 2);                // R11 chi reloaded
    chk("R11", "chi survives ack", int_pending, 1'b1);
    order(4, 0);
    // undefined ops and absent units
    tag = "nodev undef";
    order(6, 1);                                   // R12
    order(7, 0);                                   // R12
    order(0, 9);                                   // R2 out of range
    unit_en = 8'hF7;
    order(0, 3);                                   // R2 disabled
    order(3, 3);                                   // R2 no halt effect
    unit_en = '1;
    idle();

    // constrained random traffic
    tag = "random";
    for (int i = 0; i < 3000; i++) begin
      bit v; int op; int un; bit [N-1:0] rs, rd, od; bit cr;
      v  = ($urandom % 3) != 0;
      op = ($urandom % 10 < 8) ? int'($urandom % 5) : int'($urandom % 8);
      un = ($urandom % 12 == 0) ? int'(8 + $urandom % 8) : int'($urandom % 8);
      rs = ($urandom % 6 == 0) ? N'(1 << ($urandom % N)) : '0;
      rd = ($urandom % 5 == 0) ? N'(1 << ($urandom % N)) : '0;
      od = ($urandom % 4 == 0) ? N'(1 << ($urandom % N)) : '0;
      cr = ($urandom % 9 == 0);
      unit_en = ($urandom % 10 == 0) ? ~N'(1 << ($urandom % N)) : '1;
      cyc(v, op, un, rs, rd, od, cr, int'($urandom % N));
    end
    finish_run();
  end
endmodule